// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable behavioural model of a single-clock static RAM that serves as the data store of a burst-filled cache. All address, write-data and control inputs are taken in at the rising clock edge. A burst is opened by either of two strobes: one meant for the processor and one for the cache controller. Each strobe loads the external address. The remaining beats of the burst come from a two-bit beat counter that steps only on request. The beat order is linear or interleaved, chosen by a static select input.

Writes can target any set of 9-bit byte lanes, or the whole word through a global-write input. Write data is taken at the same edge as the address, and the array is updated at the next edge with no external pulse. Reads go through the array into an output register, so read data is visible one clock after the access is issued. The data bus is modelled as a data-out port plus a drive-enable port, which stands for a tri-state buffer. A static sleep input stops new accesses and keeps the array contents.

Top module: `sram_pipe_burst`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rdata` is all zeros until the first read completes. No burst is open after reset.
- R2: An access is issued at the clock edge where it is accepted. A write updates the array at the next edge. For a read, the addressed word appears on `rdata` after the next edge and stays there until another read completes.
- R3: A clock with `start_cpu` or `start_ctl` high loads `addr` as the burst base and issues an access to it. A `start_cpu` access is always a read, whatever the write inputs, including when both strobes are high.
- R4: With no strobe, `step_en` issues an access at the next beat address, but only if a burst has been opened since reset. A clock with no strobe and no `step_en`, or with `step_en` before any burst was opened, issues no access.
- R5: When `order_ilv` is 0 (linear), beat k of a burst uses the low two address bits (base + k) mod 4. The upper address bits are those of the base, and k wraps after 3.
- R6: When `order_ilv` is 1 (interleaved), beat k uses the low two address bits base XOR k. The upper bits are kept.
- R7: Outside a `start_cpu` clock, lane j (bits 9j+8 down to 9j) is written when `wr_en` and `lane_wr[j]` are both high. Unselected lanes keep their contents. If no lane is selected, the access is a read.
- R8: Outside a `start_cpu` clock, `wr_all` high writes all four lanes, whatever `wr_en` and `lane_wr` are.
- R9: `rdata_oe` is high exactly when `out_en` is high and no write accepted at the last edge is still waiting to reach the array.
- R10: While `sleep` is high, strobes and `step_en` are ignored. The beat counter and the array are kept, and an access accepted before `sleep` rose still completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | ADDR_W | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| start_cpu | input | 1 | Processor burst strobe, read only |
| start_ctl | input | 1 | Controller burst strobe |
| step_en | input | 1 | Advance to the next beat of the open burst |
| wr_en | input | 1 | Write enable qualifying `lane_wr` |
| lane_wr | input | 4 | Per-lane write selects |
| wr_all | input | 1 | Global write of all lanes |
| out_en | input | 1 | Static output enable |
| sleep | input | 1 | Static sleep, stops new accesses |
| order_ilv | input | 1 | Beat order: 0 linear, 1 interleaved |
| rdata | output | 36 | Registered read data |
| rdata_oe | output | 1 | Bus drive enable (low means high impedance) |

## Verification
The assertions assume that `sleep`, `out_en` and `order_ilv` change only away from the rising edge. They also assume that nothing is judged within two clocks of reset release. The bench drives every input one nanosecond after the falling edge and holds it through the next rising edge. Read data is compared only for addresses that the bench has fully written. Every partial-lane write goes to a word that a global write has already filled, so no lane of the array is ever undefined when it is read.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Beat order select encoding
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  localparam int BEAT_W = 2;

  // Low address bits of a burst beat: R5 linear, R6 interleaved
  function automatic logic [BEAT_W-1:0] beat_lo(
    input logic [BEAT_W-1:0] base,
    input logic [BEAT_W-1:0] step,
    input burst_order_e      ord
  );
    logic [BEAT_W-1:0] res;
    if (ord == ORD_INTERLEAVE) res = base ^ step;
    else                       res = base + step;
    return res;
  endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              start,
  input  logic              adv,
  input  burst_order_e      order,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              acc_go,
  output logic              acc_start,
  output logic [ADDR_W-1:0] acc_addr
);

  logic [ADDR_W-1:0] base_q, base_n;
  logic [BEAT_W-1:0] cnt_q, cnt_n, cnt_step;
  logic              live_q, live_n;
  logic              adv_go;

  // Next-state logic
  always_comb begin
    acc_start = run_en & start;
    adv_go    = run_en & ~start & adv & live_q;   // R4: no step before a burst opens
    cnt_step  = cnt_q + 2'd1;
    base_n    = base_q;
    cnt_n     = cnt_q;
    live_n    = live_q;
    if (acc_start) begin
      base_n = ext_addr;
      cnt_n  = '0;
      live_n = 1'b1;
    end else if (adv_go) begin
      cnt_n = cnt_step;
    end
    acc_go   = acc_start | adv_go;
    acc_addr = acc_start ? ext_addr
             : {base_q[ADDR_W-1:BEAT_W], beat_lo(base_q[BEAT_W-1:0], cnt_step, order)};
  end

  // State registers, enabled only when an access is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      live_q <= 1'b0;
    end else if (acc_go) begin
      base_q <= base_n;
      cnt_q  <= cnt_n;
      live_q <= live_n;
    end
  end

endmodule

// File: rtl/sram_lane_dec.sv
module sram_lane_dec #(
  parameter int N_LANES = 4
) (
  input  logic               read_only,
  input  logic               wr_en,
  input  logic               wr_all,
  input  logic [N_LANES-1:0] lane_wr,
  output logic [N_LANES-1:0] mask
);

  always_comb begin
    if (read_only)   mask = '0;        // R3: processor strobe forces a read
    else if (wr_all) mask = '1;        // R8: global write
    else if (wr_en)  mask = lane_wr;   // R7: per-lane write
    else             mask = '0;
  end

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int ADDR_W  = 8,
  parameter int N_LANES = 4,
  parameter int LANE_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_go,
  input  logic                      rd_go,
  input  logic [N_LANES-1:0]        mask,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N_LANES*LANE_W-1:0] wdata,
  output logic [N_LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = N_LANES * LANE_W;

  logic [DATA_W-1:0] rd_word;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_go && mask[g]) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[addr];
  end

  // Output register of the pipelined read path (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_go) rdata <= rd_word;
  end

endmodule

// File: rtl/sram_pipe_burst.sv
module sram_pipe_burst
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_LANES = 4,
  parameter int LANE_W  = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [N_LANES*LANE_W-1:0] wdata,
  input  logic                      start_cpu,
  input  logic                      start_ctl,
  input  logic                      step_en,
  input  logic                      wr_en,
  input  logic [N_LANES-1:0]        lane_wr,
  input  logic                      wr_all,
  input  logic                      out_en,
  input  logic                      sleep,
  input  logic                      order_ilv,
  output logic [N_LANES*LANE_W-1:0] rdata,
  output logic                      rdata_oe
);

  localparam int DATA_W = N_LANES * LANE_W;

  logic               acc_go, acc_start;
  logic [ADDR_W-1:0]  acc_addr;
  logic [N_LANES-1:0] wr_mask;

  logic               s1_valid_q, s1_valid_n;
  logic               s1_wr_q, s1_wr_n;
  logic [ADDR_W-1:0]  s1_addr_q;
  logic [N_LANES-1:0] s1_mask_q;
  logic [DATA_W-1:0]  s1_data_q;

  sram_burst_seq #(.ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (~sleep),
    .start     (start_cpu | start_ctl),
    .adv       (step_en),
    .order     (burst_order_e'(order_ilv)),
    .ext_addr  (addr),
    .acc_go    (acc_go),
    .acc_start (acc_start),
    .acc_addr  (acc_addr)
  );

  sram_lane_dec #(.N_LANES(N_LANES)) dec_i (
    .read_only (start_cpu),
    .wr_en     (wr_en),
    .wr_all    (wr_all),
    .lane_wr   (lane_wr),
    .mask      (wr_mask)
  );

  // Stage-one next state
  always_comb begin
    s1_valid_n = acc_go;
    s1_wr_n    = acc_go & (|wr_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_wr_q    <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_n;
      s1_wr_q    <= s1_wr_n;
    end
  end

  // Payload registers with an explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_addr_q <= '0;
      s1_mask_q <= '0;
      s1_data_q <= '0;
    end else if (acc_go) begin
      s1_addr_q <= acc_addr;
      s1_mask_q <= wr_mask;
      s1_data_q <= wdata;
    end
  end

  sram_lane_array #(.ADDR_W(ADDR_W), .N_LANES(N_LANES), .LANE_W(LANE_W)) arr_i (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_go (s1_wr_q),
    .rd_go (s1_valid_q & ~s1_wr_q),
    .mask  (s1_mask_q),
    .addr  (s1_addr_q),
    .wdata (s1_data_q),
    .rdata (rdata)
  );

  // Bus drive: off while a write waits for the array (R9)
  assign rdata_oe = out_en & ~s1_wr_q;

  logic unused_ok;
  assign unused_ok = acc_start;

endmodule

// File: rtl/sram_pipe_burst_chk.sv
module sram_pipe_burst_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_cpu,
  input logic              start_ctl,
  input logic              step_en,
  input logic              wr_all,
  input logic              out_en,
  input logic              sleep,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe
);

  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end
  assign warm = (age_q >= 2'd2);

  AST_OE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> !rdata_oe);                                                  // R9

  AST_CPU_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(start_cpu && !sleep) |-> (rdata_oe == out_en));           // R3

  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(!start_cpu && !start_ctl && !step_en) |-> (rdata_oe == out_en)); // R4

  AST_GLOBAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(wr_all && start_ctl && !start_cpu && !sleep) |-> !rdata_oe); // R8

  AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(sleep) |-> (rdata_oe == out_en));                          // R10

  AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    warm && $past(sleep, 2) |-> $stable(rdata));                             // R10

endmodule

bind sram_pipe_burst sram_pipe_burst_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_cpu (start_cpu),
  .start_ctl (start_ctl),
  .step_en   (step_en),
  .wr_all    (wr_all),
  .out_en    (out_en),
  .sleep     (sleep),
  .rdata     (rdata),
  .rdata_oe  (rdata_oe)
);

// File: tb/sram_pipe_burst_tb_top.sv
`timescale 1ns/1ps
module sram_pipe_burst_tb_top;

  localparam int ADDR_W  = 8;
  localparam int N_LANES = 4;
  localparam int LANE_W  = 9;
  localparam int DATA_W  = N_LANES * LANE_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic              start_cpu, start_ctl, step_en, wr_en, wr_all;
  logic [N_LANES-1:0] lane_wr;
  logic              out_en, sleep, order_ilv;
  logic [DATA_W-1:0] rdata;
  logic              rdata_oe;

  int    checks = 0;
  int    fails  = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #2 clk = ~clk;   // 250 MHz

  sram_pipe_burst #(.ADDR_W(ADDR_W), .N_LANES(N_LANES), .LANE_W(LANE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .start_cpu(start_cpu), .start_ctl(start_ctl), .step_en(step_en),
    .wr_en(wr_en), .lane_wr(lane_wr), .wr_all(wr_all),
    .out_en(out_en), .sleep(sleep), .order_ilv(order_ilv),
    .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // ---------------- reference model ----------------
  logic [DATA_W-1:0] mem_m [int];
  bit                p_valid, p_wr;
  logic [N_LANES-1:0] p_mask;
  int                p_addr;
  logic [DATA_W-1:0] p_data;
  int                m_base, m_cnt;
  bit                m_live;
  logic [DATA_W-1:0] m_rdata;
  bit                m_known;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_valid = 0; p_wr = 0; m_live = 0; m_base = 0; m_cnt = 0;
      m_rdata = '0; m_known = 1;
    end else begin
      if (p_valid) begin
        if (p_wr) begin
          logic [DATA_W-1:0] w;
          w = mem_m.exists(p_addr) ? mem_m[p_addr] : '0;
          for (int j = 0; j < N_LANES; j++)
            if (p_mask[j]) w[j*LANE_W +: LANE_W] = p_data[j*LANE_W +: LANE_W];
          mem_m[p_addr] = w;
        end else if (mem_m.exists(p_addr)) begin
          m_rdata = mem_m[p_addr]; m_known = 1;
        end else begin
          m_known = 0;
        end
      end
      p_valid = 0; p_wr = 0;
      if (!sleep) begin
        if (start_cpu || start_ctl) begin
          m_base = int'(addr); m_cnt = 0; m_live = 1; p_valid = 1; p_addr = m_base;
        end else if (step_en && m_live) begin
          m_cnt = (m_cnt + 1) % 4; p_valid = 1;
          if (order_ilv) p_addr = (m_base & ~3) | ((m_base & 3) ^ m_cnt);
          else           p_addr = (m_base & ~3) | (((m_base & 3) + m_cnt) % 4);
        end
        if (p_valid && !start_cpu) begin
          if (wr_all)     p_mask = '1;
          else if (wr_en) p_mask = lane_wr;
          else            p_mask = '0;
          p_wr   = (p_mask != '0);
          p_data = wdata;
        end
      end
    end
  end

  // ---------------- comparison, every clock ----------------
  always @(negedge clk) begin
    if (!done) begin
      bit exp_oe;
      exp_oe = out_en && !(p_valid && p_wr);
      checks++;
      if (rdata_oe !== exp_oe) begin
        fails++;
        $display("FAIL %s rdata_oe actual=%0b expected=%0b t=%0t", cur_req, rdata_oe, exp_oe, $time);
      end
      if (m_known) begin
        checks++;
        if (rdata !== m_rdata) begin
          fails++;
          $display("FAIL %s rdata actual=%h expected=%h t=%0t", cur_req, rdata, m_rdata, $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [DATA_W-1:0] pat(input int a, input int salt);
    logic [7:0] b;
    b = 8'(a);
    return {4'(salt), b, 8'h5C ^ 8'(salt), b ^ 8'h33, ~b};
  endfunction

  task automatic drive(input bit sc, input bit st, input bit sp, input int a,
                       input logic [DATA_W-1:0] d, input bit we,
                       input logic [N_LANES-1:0] lw, input bit wa);
    @(negedge clk); #1;
    start_cpu = sc; start_ctl = st; step_en = sp; addr = ADDR_W'(a);
    wdata = d; wr_en = we; lane_wr = lw; wr_all = wa;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, '0, 0, '0, 0);
  endtask

  // Fill four words of an aligned block with a global-write burst
  task automatic fill_block(input int base, input int salt);
    drive(0, 1, 0, base, pat(base, salt), 0, '0, 1);
    for (int k = 1; k < 4; k++) begin
      int a;
      a = (base & ~3) | (((base & 3) + k) % 4);
      drive(0, 0, 1, 0, pat(a, salt), 0, '0, 1);
    end
  endtask

  // Watchdog
  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; out_en = 1; sleep = 0; order_ilv = 0;
    start_cpu = 0; start_ctl = 0; step_en = 0; addr = '0; wdata = '0;
    wr_en = 0; lane_wr = '0; wr_all = 0;
    // R1: reset state observed by the comparison block
    cur_req = "R1";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    idle(2);

    // R4: step before any burst opens does nothing
    cur_req = "R4";
    drive(0, 0, 1, 0, pat(0, 1), 0, '0, 1);
    drive(0, 0, 1, 0, pat(0, 1), 0, '0, 1);
    idle(2);

    // R8: global writes, linear fill of two blocks
    cur_req = "R8";
    fill_block(8'h10, 1);
    fill_block(8'h22, 2);
    // global write overriding wr_en low and no lanes
    drive(0, 1, 0, 8'h40, pat(8'h40, 3), 0, '0, 1);
    idle(2);

    // R2 / R5: linear read burst from an unaligned base, wraps in block
    cur_req = "R5";
    drive(1, 0, 0, 8'h12, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);   // wraps back to the base
    cur_req = "R2";
    idle(3);
    drive(1, 0, 0, 8'h40, '0, 0, '0, 0);
    idle(1);                            // suspend: no access, data held
    idle(2);

    // R6: interleaved read burst
    cur_req = "R6";
    order_ilv = 1;
    drive(0, 1, 0, 8'h23, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(1, 0, 0, 8'h21, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    idle(2);
    order_ilv = 0;

    // R7: lane writes, empty lane set, full lane set
    cur_req = "R7";
    drive(0, 1, 0, 8'h11, {DATA_W{1'b1}}, 1, 4'b0101, 0);
    drive(0, 1, 0, 8'h11, '0, 0, '0, 0);
    drive(0, 1, 0, 8'h13, '0, 1, 4'b1010, 0);
    drive(0, 1, 0, 8'h13, '0, 1, 4'b0000, 0);   // no lane: read
    drive(0, 1, 0, 8'h10, pat(7, 9), 1, 4'b1111, 0);
    drive(0, 0, 1, 0, {DATA_W{1'b1}}, 1, 4'b1000, 0);
    drive(0, 1, 0, 8'h10, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    idle(2);

    // R3: processor strobe with write inputs stays a read; both strobes
    cur_req = "R3";
    drive(1, 0, 0, 8'h22, pat(1, 4), 1, 4'b1111, 1);
    drive(1, 1, 0, 8'h23, pat(2, 4), 1, 4'b1111, 1);
    drive(0, 1, 0, 8'h22, '0, 0, '0, 0);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    idle(2);

    // R9: output enable against pending writes
    cur_req = "R9";
    out_en = 0;
    drive(0, 1, 0, 8'h24, pat(8'h24, 5), 0, '0, 1);
    drive(0, 1, 0, 8'h24, '0, 0, '0, 0);
    out_en = 1;
    drive(0, 1, 0, 8'h25, pat(8'h25, 5), 0, '0, 1);
    drive(0, 0, 1, 0, pat(8'h26, 5), 0, '0, 1);
    drive(0, 0, 1, 0, '0, 0, '0, 0);
    drive(0, 1, 0, 8'h25, '0, 0, '0, 0);
    idle(2);

    // R10: sleep ignores strobes and steps, keeps contents and counter
    cur_req = "R10";
    drive(0, 1, 0, 8'h10, '0, 0, '0, 0);
    sleep = 1;
    drive(0, 1, 0, 8'h10, pat(0, 6), 0, '0, 1);
    drive(0, 0, 1, 0, pat(0, 6), 0, '0, 1);
    drive(1, 0, 0, 8'h40, '0, 0, '0, 0);
    idle(2);
    sleep = 0;
    drive(0, 0, 1, 0, '0, 0, '0, 0);      // continues the pre-sleep burst
    drive(0, 1, 0, 8'h10, '0, 0, '0, 0);
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule